// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes command bytes that a host writes to a flash device and chooses what the data pins return. The host side uses four active-low controls: chip enable, output enable, write enable and reset/power-down. A write completes on the rising edge of write enable while chip enable is low. The written byte is a command, or the address and data of a program operation. Reads return one of three views: the memory array, a two-byte identifier, or an 8-bit status register. The controller keeps a small register-based array model, and it stands in for the write state machine with a countdown.

Program and block-erase run in the background. While a job runs, reads are forced to the status view. During an erase, only the suspend command is taken. Suspend freezes the countdown so the array can be read, and resume continues the same countdown. When a job finishes, the controller stays in the status view. The write-voltage-valid input gates whether a job may start. Reads never depend on it.

The states are:

| State | Role |
| --- | --- |
| READ_ARRAY | Array reads |
| READ_ID | Identifier reads |
| READ_STATUS | Status reads |
| PROG_SETUP | Waits for the program address and data |
| ERASE_SETUP | Waits for the erase confirm |
| PROG_BUSY | Program countdown running |
| ERASE_BUSY | Erase countdown running |
| ERASE_SUSP | Erase paused |

From the three read states, a write moves the controller as follows: 0xFF goes to READ_ARRAY, 0x90 to READ_ID, 0x70 to READ_STATUS, 0x40 or 0x10 to PROG_SETUP, and 0x20 to ERASE_SETUP. A write of 0x50 clears the error bits and keeps the current state. Any other byte is ignored.

The remaining transitions are:

- PROG_SETUP: the next write goes to PROG_BUSY, or to READ_STATUS if the write voltage is low.
- ERASE_SETUP: 0xD0 goes to ERASE_BUSY. If the write voltage is low, or the byte is not 0xD0, it goes to READ_STATUS with errors set.
- PROG_BUSY: goes to READ_STATUS when the countdown ends.
- ERASE_BUSY: goes to READ_STATUS when the countdown ends, or to ERASE_SUSP on 0xB0.
- ERASE_SUSP: 0xD0 goes back to ERASE_BUSY. 0x70 selects the status view and 0xFF the array view.
- Any state: reset, or holding power-down low, returns to READ_ARRAY.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and in the cycle after power-down (rp_n) is released, the controller is in READ_ARRAY without any command. While rp_n is low, dout_oe is 0, any job in progress is abandoned, and the status error bits are cleared.
- R2: dout_oe is 1 only when ce_n=0, oe_n=0, we_n=1 and rp_n=1. dout is 0 whenever dout_oe is 0.
- R3: Each read view is selected only by its command. 0xFF selects the array. 0x90 selects the identifier, which returns MFR_CODE when addr bit 0 is 0 and DEV_CODE when it is 1. 0x70 selects status. Status bits: bit 7 is ready (1 = no job running), bit 6 is erase suspended, bit 5 is erase error, bit 4 is program error, bit 3 is write voltage low, and bits 2..0 read 0.
- R4: Writing 0x40 or 0x10, then an address and data byte, starts a program job. PROG_CYCLES cycles after that write, the addressed word becomes old AND data. Until then, every read returns status with bit 7 at 0.
- R5: Every byte written while a program job runs is ignored.
- R6: Writing 0x20 and then 0xD0 starts an erase of the block selected by addr[ADDR_W-1:BLK_OFS_W] of the confirm write. After ERASE_CYCLES running cycles, every word of that block reads 0xFF and other blocks are unchanged. While the erase runs, only 0xB0 is accepted.
- R7: 0xB0 during an erase suspends it. Status then reads 0xC0 and reads return array data until 0x70 is written. The countdown does not advance while suspended. 0xD0 resumes the erase with the count it had left.
- R8: When a job ends, the controller is in READ_STATUS with bit 7 set. 0xFF is needed to read the array, and a new program or erase may be started directly from there.
- R9: If vpp_ok is 0 when the program data write or the erase confirm arrives, no job starts. Bit 3 is set, together with bit 4 (program) or bit 5 (erase), and the controller goes to READ_STATUS. Reads in all views work whatever vpp_ok is.
- R10: After 0x20, any byte other than 0xD0 sets bits 5 and 4, erases nothing, and goes to READ_STATUS.
- R11: Bits 5, 4 and 3 stay set through other commands until 0x50 is written in a read state, which clears them.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write completes on its rising edge |
| rp_n | input | 1 | Reset/power-down, active low |
| vpp_ok | input | 1 | Write voltage valid |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Write data or command byte |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Drive enable for dout; 0 means the pins are released |

## Verification
A wrong state shows at the data pins on the first read after the faulty write. For example, a mode entered without its command returns array bytes where status or identifier bytes were due. A countdown that is lost, or that restarts after resume, shows as a ready bit that sets too early or too late. The bench catches this by reading status within a couple of cycles of each start, suspend and resume, and again inside a window that only the correct remaining count fits. Wrong masking or block decode in a job shows as array bytes that differ on the readback just after the controller returns to the array view.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READ_ARRAY,
        ST_READ_ID,
        ST_READ_STATUS,
        ST_PROG_SETUP,
        ST_ERASE_SETUP,
        ST_PROG_BUSY,
        ST_ERASE_BUSY,
        ST_ERASE_SUSP
    } fc_state_e;

    typedef enum logic [3:0] {
        CMD_RD_ARRAY,
        CMD_RD_ID,
        CMD_RD_STATUS,
        CMD_CLR_STATUS,
        CMD_PROG_SETUP,
        CMD_ERASE_SETUP,
        CMD_CONFIRM,
        CMD_SUSPEND,
        CMD_OTHER
    } fc_cmd_e;

    localparam logic [7:0] BYTE_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] BYTE_RD_ID     = 8'h90;
    localparam logic [7:0] BYTE_RD_STATUS = 8'h70;
    localparam logic [7:0] BYTE_CLR_STAT  = 8'h50;
    localparam logic [7:0] BYTE_PROG_A    = 8'h40;
    localparam logic [7:0] BYTE_PROG_B    = 8'h10;
    localparam logic [7:0] BYTE_ERASE     = 8'h20;
    localparam logic [7:0] BYTE_CONFIRM   = 8'hD0;
    localparam logic [7:0] BYTE_SUSPEND   = 8'hB0;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output fc_cmd_e    cmd
);

    always_comb begin
        unique case (cmd_byte)
            BYTE_RD_ARRAY:             cmd = CMD_RD_ARRAY;
            BYTE_RD_ID:                cmd = CMD_RD_ID;
            BYTE_RD_STATUS:            cmd = CMD_RD_STATUS;
            BYTE_CLR_STAT:             cmd = CMD_CLR_STATUS;
            BYTE_PROG_A, BYTE_PROG_B:  cmd = CMD_PROG_SETUP;
            BYTE_ERASE:                cmd = CMD_ERASE_SETUP;
            BYTE_CONFIRM:              cmd = CMD_CONFIRM;
            BYTE_SUSPEND:              cmd = CMD_SUSPEND;
            default:                   cmd = CMD_OTHER;
        endcase
    end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == CNT_W'(1));

    // R7: a paused countdown keeps its remaining count
    assert_paused_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/flash_mem_model.sv
module flash_mem_model #(
    parameter int ADDR_W = 6,
    parameter int OFS_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prog_en,
    input  logic [ADDR_W-1:0]       prog_addr,
    input  logic [7:0]              prog_data,
    input  logic                    erase_en,
    input  logic [ADDR_W-OFS_W-1:0] erase_blk,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [ADDR_W-1:0] WA = ADDR_W'(g);
        logic [7:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= 8'hFF;
            end else if (erase_en && WA[ADDR_W-1:OFS_W] == erase_blk) begin
                word_q <= 8'hFF;
            end else if (prog_en && prog_addr == WA) begin
                word_q <= word_q & prog_data;
            end
        end

        assign words[g] = word_q;

        // R4: programming can only clear bits the data byte has at zero
        assert_prog_clears_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_en && !erase_en && prog_addr == WA) |=> ((word_q & ~$past(prog_data)) == 8'h00));
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W       = 6,
    parameter int         BLK_OFS_W    = 4,
    parameter int         PROG_CYCLES  = 6,
    parameter int         ERASE_CYCLES = 24,
    parameter logic [7:0] MFR_CODE     = 8'h5A,
    parameter logic [7:0] DEV_CODE     = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rp_n,
    input  logic              vpp_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_oe
);

    localparam int BLK_W   = ADDR_W - BLK_OFS_W;
    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    fc_state_e          state_q, state_d;
    fc_cmd_e            cmd;
    logic               we_prev_q;
    logic               wr_stb;
    logic [ADDR_W-1:0]  op_addr_q;
    logic [7:0]         op_data_q;
    logic [BLK_W-1:0]   op_blk_q;
    logic               sr_erase_err_q, sr_prog_err_q, sr_vlow_q;
    logic               view_status_q;
    logic               tmr_load, tmr_done, tmr_run;
    logic [TMR_W-1:0]   tmr_val;
    logic               cap_prog, cap_erase;
    logic               set_perr, set_eerr, set_vlow, clr_sr;
    logic               view_to_status, view_to_array;
    logic               job_busy;
    logic [7:0]         status_byte, id_byte, arr_byte, rd_byte;

    assign wr_stb = rp_n && !ce_n && we_n && !we_prev_q;

    flash_cmd_decode u_decode (
        .cmd_byte (din),
        .cmd      (cmd)
    );

    assign job_busy = (state_q == ST_PROG_BUSY) || (state_q == ST_ERASE_BUSY);
    assign tmr_run  = job_busy;

    flash_op_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!rp_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .done     (tmr_done)
    );

    flash_mem_model #(.ADDR_W(ADDR_W), .OFS_W(BLK_OFS_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (tmr_done && state_q == ST_PROG_BUSY),
        .prog_addr (op_addr_q),
        .prog_data (op_data_q),
        .erase_en  (tmr_done && state_q == ST_ERASE_BUSY),
        .erase_blk (op_blk_q),
        .rd_addr   (addr),
        .rd_data   (arr_byte)
    );

    // next state and control pulses
    always_comb begin
        state_d        = state_q;
        tmr_load       = 1'b0;
        tmr_val        = '0;
        cap_prog       = 1'b0;
        cap_erase      = 1'b0;
        set_perr       = 1'b0;
        set_eerr       = 1'b0;
        set_vlow       = 1'b0;
        clr_sr         = 1'b0;
        view_to_status = 1'b0;
        view_to_array  = 1'b0;
        unique case (state_q)
            ST_READ_ARRAY, ST_READ_ID, ST_READ_STATUS: begin
                if (wr_stb) begin
                    case (cmd)
                        CMD_RD_ARRAY:    state_d = ST_READ_ARRAY;
                        CMD_RD_ID:       state_d = ST_READ_ID;
                        CMD_RD_STATUS:   state_d = ST_READ_STATUS;
                        CMD_CLR_STATUS:  clr_sr  = 1'b1;
                        CMD_PROG_SETUP:  state_d = ST_PROG_SETUP;
                        CMD_ERASE_SETUP: state_d = ST_ERASE_SETUP;
                        default:         state_d = state_q;
                    endcase
                end
            end
            ST_PROG_SETUP: begin
                if (wr_stb) begin
                    if (vpp_ok) begin
                        cap_prog = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(PROG_CYCLES);
                        state_d  = ST_PROG_BUSY;
                    end else begin
                        set_perr = 1'b1;
                        set_vlow = 1'b1;
                        state_d  = ST_READ_STATUS;
                    end
                end
            end
            ST_ERASE_SETUP: begin
                if (wr_stb) begin
                    if (cmd == CMD_CONFIRM && vpp_ok) begin
                        cap_erase = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(ERASE_CYCLES);
                        state_d   = ST_ERASE_BUSY;
                    end else if (cmd == CMD_CONFIRM) begin
                        set_eerr = 1'b1;
                        set_vlow = 1'b1;
                        state_d  = ST_READ_STATUS;
                    end else begin
                        set_eerr = 1'b1;
                        set_perr = 1'b1;
                        state_d  = ST_READ_STATUS;
                    end
                end
            end
            ST_PROG_BUSY: begin
                if (tmr_done) state_d = ST_READ_STATUS;
            end
            ST_ERASE_BUSY: begin
                if (tmr_done) begin
                    state_d = ST_READ_STATUS;
                end else if (wr_stb && cmd == CMD_SUSPEND) begin
                    state_d       = ST_ERASE_SUSP;
                    view_to_array = 1'b1;
                end
            end
            ST_ERASE_SUSP: begin
                if (wr_stb) begin
                    case (cmd)
                        CMD_CONFIRM:   state_d        = ST_ERASE_BUSY;
                        CMD_RD_STATUS: view_to_status = 1'b1;
                        CMD_RD_ARRAY:  view_to_array  = 1'b1;
                        default:       state_d        = state_q;
                    endcase
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ_ARRAY;
        end else if (!rp_n) begin
            state_q <= ST_READ_ARRAY;
        end else begin
            state_q <= state_d;
        end
    end

    // latched job parameters, status bits and suspend view
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_prev_q      <= 1'b1;
            op_addr_q      <= '0;
            op_data_q      <= 8'hFF;
            op_blk_q       <= '0;
            sr_erase_err_q <= 1'b0;
            sr_prog_err_q  <= 1'b0;
            sr_vlow_q      <= 1'b0;
            view_status_q  <= 1'b0;
        end else if (!rp_n) begin
            we_prev_q      <= 1'b1;
            sr_erase_err_q <= 1'b0;
            sr_prog_err_q  <= 1'b0;
            sr_vlow_q      <= 1'b0;
            view_status_q  <= 1'b0;
        end else begin
            we_prev_q <= we_n;
            if (cap_prog) begin
                op_addr_q <= addr;
                op_data_q <= din;
            end
            if (cap_erase) op_blk_q <= addr[ADDR_W-1:BLK_OFS_W];
            if (clr_sr) begin
                sr_erase_err_q <= 1'b0;
                sr_prog_err_q  <= 1'b0;
                sr_vlow_q      <= 1'b0;
            end else begin
                if (set_eerr) sr_erase_err_q <= 1'b1;
                if (set_perr) sr_prog_err_q  <= 1'b1;
                if (set_vlow) sr_vlow_q      <= 1'b1;
            end
            if (view_to_status)     view_status_q <= 1'b1;
            else if (view_to_array) view_status_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        status_byte = {!job_busy, state_q == ST_ERASE_SUSP, sr_erase_err_q,
                       sr_prog_err_q, sr_vlow_q, 3'b000};
        id_byte     = addr[0] ? DEV_CODE : MFR_CODE;
        unique case (state_q)
            ST_READ_ARRAY: rd_byte = arr_byte;
            ST_READ_ID:    rd_byte = id_byte;
            ST_ERASE_SUSP: rd_byte = view_status_q ? status_byte : arr_byte;
            ST_READ_STATUS, ST_PROG_SETUP, ST_ERASE_SETUP,
            ST_PROG_BUSY, ST_ERASE_BUSY: rd_byte = status_byte;
        endcase
        dout_oe = rp_n && !ce_n && !oe_n && we_n;
        dout    = dout_oe ? rd_byte : 8'h00;
    end

    // R1: power-down always lands in array reads
    assert_pd_to_array_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_n |=> (state_q == ST_READ_ARRAY));

    // R5: nothing but completion leaves a running program
    assert_prog_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_BUSY && !tmr_done && rp_n) |=> (state_q == ST_PROG_BUSY));

    // R6: a running erase only leaves on completion or suspend
    assert_erase_only_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE_BUSY && !tmr_done && rp_n && !(wr_stb && cmd == CMD_SUSPEND))
        |=> (state_q == ST_ERASE_BUSY));

    // R8: job completion parks in status reads
    assert_done_to_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_done && rp_n) |=> (state_q == ST_READ_STATUS));

    // R9: low write voltage never starts a job
    assert_lowv_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !vpp_ok && (state_q == ST_PROG_SETUP || state_q == ST_ERASE_SETUP))
        |=> (state_q == ST_READ_STATUS && sr_vlow_q));

    // R11: error bits are sticky until explicitly cleared
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_prog_err_q && rp_n && !clr_sr) |=> sr_prog_err_q);

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, vpp_ok = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rp_n(rp_n), .vpp_ok(vpp_ok), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    typedef struct {
        logic [7:0] exp;
        logic       exp_oe;
        logic       oe_only;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    sb_item_t it;
    event smp_ev;

    // monitor: pops one expected item per sample point
    initial begin
        forever begin
            @(smp_ev);
            it = sb_q.pop_front();
            n_chk++;
            if (it.oe_only) begin
                if (dout_oe !== it.exp_oe) begin
                    n_fail++;
                    $display("FAIL %s: dout_oe=%0b expected %0b", it.tag, dout_oe, it.exp_oe);
                end
            end else if (dout_oe !== 1'b1 || dout !== it.exp) begin
                n_fail++;
                $display("FAIL %s: oe=%0b dout=%02h expected oe=1 dout=%02h",
                         it.tag, dout_oe, dout, it.exp);
            end
        end
    end

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        #1;
        sb_q.push_back('{e, 1'b1, 1'b0, tag});
        -> smp_ev;
    endtask

    task automatic pins(input logic c, input logic o, input logic w,
                        input logic e_oe, input string tag);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w;
        #1;
        sb_q.push_back('{8'h00, e_oe, 1'b1, tag});
        -> smp_ev;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 / R1: reset state
        pins(1'b1, 1'b0, 1'b1, 1'b0, "R2 standby releases pins");
        rd(6'h00, 8'hFF, "R1 array view after reset");
        pins(1'b0, 1'b1, 1'b1, 1'b0, "R2 output disable");
        pins(1'b0, 1'b0, 1'b0, 1'b0, "R2 write enable low blocks drive");

        // R3: identifier and status views
        wr(6'h00, 8'h90);
        rd(6'h00, 8'h5A, "R3 maker code");
        rd(6'h01, 8'hC3, "R3 device code");
        wr(6'h00, 8'h70);
        rd(6'h00, 8'h80, "R3 status idle");
        wr(6'h00, 8'hFF);
        rd(6'h01, 8'hFF, "R3 back to array");

        // R4: program a word in block 1
        wr(6'h00, 8'h40);
        wr(6'h14, 8'h0F);
        idle(10);
        rd(6'h00, 8'h80, "R8 ready after program");

        // R4 / R5: program word 5, commands ignored while running
        wr(6'h00, 8'h40);
        wr(6'h05, 8'h3C);
        rd(6'h00, 8'h00, "R4 busy status during program");
        wr(6'h00, 8'hFF);
        rd(6'h05, 8'h00, "R5 read-array ignored while programming");
        idle(6);
        rd(6'h05, 8'h80, "R8 stays in status after program");
        wr(6'h00, 8'hFF);
        rd(6'h05, 8'h3C, "R4 programmed value");
        wr(6'h00, 8'h10);
        wr(6'h05, 8'hF0);
        idle(10);
        wr(6'h00, 8'hFF);
        rd(6'h05, 8'h30, "R4 program only clears bits");

        // R9 / R11: low write voltage
        vpp_ok = 1'b0;
        wr(6'h00, 8'h40);
        wr(6'h06, 8'h00);
        rd(6'h00, 8'h98, "R9 low voltage program refused");
        wr(6'h00, 8'hFF);
        rd(6'h06, 8'hFF, "R9 array untouched and readable");
        wr(6'h00, 8'h90);
        rd(6'h01, 8'hC3, "R9 identifier readable at low voltage");
        wr(6'h00, 8'h70);
        rd(6'h00, 8'h98, "R11 errors sticky");
        wr(6'h00, 8'h50);
        rd(6'h00, 8'h80, "R11 clear status");
        vpp_ok = 1'b1;

        // R10: bad erase sequence
        wr(6'h00, 8'h20);
        wr(6'h00, 8'hFF);
        rd(6'h00, 8'hB0, "R10 sequence error bits");
        wr(6'h00, 8'hFF);
        rd(6'h05, 8'h30, "R10 nothing erased");
        wr(6'h00, 8'h50);

        // R6 / R7: erase block 0 with suspend and resume
        wr(6'h00, 8'h20);
        wr(6'h03, 8'hD0);
        rd(6'h00, 8'h00, "R6 busy status during erase");
        wr(6'h00, 8'hFF);
        rd(6'h05, 8'h00, "R6 read-array ignored while erasing");
        wr(6'h00, 8'hB0);
        rd(6'h05, 8'h30, "R7 array readable while suspended");
        idle(40);
        wr(6'h00, 8'h70);
        rd(6'h00, 8'hC0, "R7 suspended status holds");
        wr(6'h00, 8'hD0);
        rd(6'h00, 8'h00, "R7 busy after resume");
        repeat (18) @(negedge clk);
        rd(6'h00, 8'h80, "R7 resumed erase finished with remaining count");
        wr(6'h00, 8'hFF);
        rd(6'h05, 8'hFF, "R6 erased block");
        rd(6'h14, 8'h0F, "R6 other block kept");

        // R8: new program directly from status after a job
        wr(6'h00, 8'h70);
        wr(6'h00, 8'h40);
        wr(6'h07, 8'h55);
        idle(10);
        rd(6'h00, 8'h80, "R8 program started from status");
        wr(6'h00, 8'hFF);
        rd(6'h07, 8'h55, "R8 program result");

        // R1: power-down aborts and returns to array reads
        wr(6'h00, 8'h40);
        wr(6'h08, 8'h00);
        @(negedge clk);
        rp_n = 1'b0;
        pins(1'b0, 1'b0, 1'b1, 1'b0, "R1 pins released in power-down");
        repeat (2) @(negedge clk);
        rp_n = 1'b1;
        rd(6'h08, 8'hFF, "R1 array view after power-down, job abandoned");
        idle(10);
        rd(6'h08, 8'hFF, "R1 no late program after power-down");

        idle(2);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule